// File: doc/BRIEF.md
# Combinational Integer ALU

This block is a purely combinational arithmetic logic unit for a 32-bit integer datapath. It takes two operands and a 4-bit operation select. It returns a 32-bit result and a flag that is high when that result is all zeros. Seven operations are defined: wrapping addition, wrapping subtraction, four bitwise operations (AND, OR, XOR, NOR) and a set-less-than comparison.

Subtraction and set-less-than share the adder that addition uses. For them, the second operand is inverted and the carry-in is 1. The adder's carry-out is discarded. Set-less-than returns the sign bit of the difference, zero-extended. It applies no overflow correction, so operands whose difference overflows give the raw sign bit rather than the true signed ordering.

The block holds no state and takes no clock. An instantiating pipeline places it between its own register stages. Select codes outside the defined set drive an all-zeros result.

Top module: `alu_core`

## Requirements
- R1: Select 4'b0000 gives a_in + b_in modulo 2^32; for example 0xFFFFFFFF + 1 gives 0.
- R2: Select 4'b0010 gives a_in - b_in modulo 2^32; for example 0 - 1 gives 0xFFFFFFFF.
- R3: Select 4'b0100 gives the bitwise AND of a_in and b_in.
- R4: Select 4'b0101 gives the bitwise OR of a_in and b_in.
- R5: Select 4'b0110 gives the bitwise XOR of a_in and b_in.
- R6: Select 4'b0111 gives the bitwise NOR of a_in and b_in.
- R7: Select 4'b1010 gives bit 31 of (a_in - b_in mod 2^32) in result bit 0, with bits 31..1 zero. No overflow correction is made, so a_in = 0x7FFFFFFF with b_in = 0x80000000 gives 1.
- R8: zero_out is 1 exactly when all 32 bits of result_out are 0, for every defined select, including a false set-less-than.
- R9: The outputs follow a change of the inputs with no clock edge involved: they are valid in the same cycle that the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| op_sel | input | 4 | Operation select |
| result_out | output | 32 | Operation result |
| zero_out | output | 1 | High when result_out is all zeros |

## Verification
Every result of this block is due in the cycle its operands are applied, because no register lies between the inputs and the outputs. The driver applies each vector just after a rising edge of the bench clock and pushes the expected result and zero flag into a queue. The monitor pops and compares them at the following falling edge, half a period later, once the combinational paths have settled. The directed vectors cover the wrap cases, the signed extremes, equal operands and the overflowing set-less-than case. Several thousand random vectors follow for each defined select.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned SEL_W  = 4;

    // Operation select encoding. Bits [3:2] = 2'b01 mark the bitwise group,
    // and bits [1:0] then pick the bitwise function inside that group.
    typedef enum logic [SEL_W-1:0] {
        SEL_ADD = 4'b0000,
        SEL_SUB = 4'b0010,
        SEL_AND = 4'b0100,
        SEL_OR  = 4'b0101,
        SEL_XOR = 4'b0110,
        SEL_NOR = 4'b0111,
        SEL_SLT = 4'b1010
    } alu_sel_e;

    typedef enum logic [1:0] {
        BW_AND = 2'b00,
        BW_OR  = 2'b01,
        BW_XOR = 2'b10,
        BW_NOR = 2'b11
    } bitwise_fn_e;

    // Decoded controls that steer the datapath.
    typedef struct packed {
        logic        invert_b;   // feed ~b and carry-in 1 to the adder
        logic        pick_sum;   // result taken from the adder
        logic        pick_bw;    // result taken from the bitwise unit
        logic        pick_slt;   // result is the sign of the difference
        bitwise_fn_e bw_fn;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
#(
    parameter int unsigned SEL_WIDTH = SEL_W
) (
    input  logic [SEL_WIDTH-1:0] sel_i,
    output alu_ctrl_t            ctrl_o
);

    alu_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d          = '0;
        ctrl_d.bw_fn    = bitwise_fn_e'(sel_i[1:0]);
        case (sel_i)
            SEL_ADD: begin
                ctrl_d.pick_sum = 1'b1;
            end
            SEL_SUB: begin
                ctrl_d.invert_b = 1'b1;
                ctrl_d.pick_sum = 1'b1;
            end
            SEL_AND, SEL_OR, SEL_XOR, SEL_NOR: begin
                ctrl_d.pick_bw  = 1'b1;
            end
            SEL_SLT: begin
                ctrl_d.invert_b = 1'b1;
                ctrl_d.pick_slt = 1'b1;
            end
            default: begin
                // unlisted selects: no source picked, result is all zeros
                ctrl_d.pick_sum = 1'b0;
            end
        endcase
    end

    assign ctrl_o = ctrl_d;

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             invert_i,
    output logic [WIDTH-1:0] sum_o
);

    localparam int unsigned EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] y_eff_d;
    logic [EXT_W-1:0] full_d;

    always_comb begin
        y_eff_d = invert_i ? ~y_i : y_i;
        // one adder for add, subtract and compare; carry-in realises +1
        full_d  = {1'b0, x_i} + {1'b0, y_eff_d} + {{WIDTH{1'b0}}, invert_i};
    end

    // carry-out (full_d[WIDTH]) is discarded
    assign sum_o = full_d[WIDTH-1:0];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  bitwise_fn_e      fn_i,
    output logic [WIDTH-1:0] out_o
);

    logic [WIDTH-1:0] out_d;

    // per-bit four-input mux keeps the logic depth to one gate plus a mux
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            case (fn_i)
                BW_AND:  out_d[i] = x_i[i] & y_i[i];
                BW_OR:   out_d[i] = x_i[i] | y_i[i];
                BW_XOR:  out_d[i] = x_i[i] ^ y_i[i];
                default: out_d[i] = ~(x_i[i] | y_i[i]);
            endcase
        end
    end

    assign out_o = out_d;

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH     = DATA_W,
    parameter int unsigned SEL_WIDTH = SEL_W
) (
    input  logic [WIDTH-1:0]     a_in,
    input  logic [WIDTH-1:0]     b_in,
    input  logic [SEL_WIDTH-1:0] op_sel,
    output logic [WIDTH-1:0]     result_out,
    output logic                 zero_out
);

    localparam int unsigned SIGN_BIT = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] bw_out;
    logic [WIDTH-1:0] result_d;

    alu_decode #(.SEL_WIDTH(SEL_WIDTH)) u_decode (
        .sel_i  (op_sel),
        .ctrl_o (ctrl)
    );

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .x_i      (a_in),
        .y_i      (b_in),
        .invert_i (ctrl.invert_b),
        .sum_o    (sum)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .x_i   (a_in),
        .y_i   (b_in),
        .fn_i  (ctrl.bw_fn),
        .out_o (bw_out)
    );

    // AND-OR result mux: the decoder picks at most one source
    always_comb begin
        result_d = ({WIDTH{ctrl.pick_sum}} & sum)
                 | ({WIDTH{ctrl.pick_bw}}  & bw_out)
                 | {{(WIDTH-1){1'b0}}, ctrl.pick_slt & sum[SIGN_BIT]};
    end

    assign result_out = result_d;
    assign zero_out   = ~|result_d;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH     = DATA_W,
    parameter int unsigned SEL_WIDTH = SEL_W
) (
    input logic [WIDTH-1:0]     a_in,
    input logic [WIDTH-1:0]     b_in,
    input logic [SEL_WIDTH-1:0] op_sel,
    input logic [WIDTH-1:0]     result_out,
    input logic                 zero_out
);

    logic [WIDTH-1:0] diff_ref;

    always_comb begin
        diff_ref = a_in - b_in;
        if (op_sel == SEL_ADD) begin
            assert_add_R1: assert (result_out == a_in + b_in);
        end
        if (op_sel == SEL_SUB) begin
            assert_sub_R2: assert (result_out == diff_ref);
        end
        if (op_sel == SEL_AND) begin
            assert_and_R3: assert (result_out == (a_in & b_in));
        end
        if (op_sel == SEL_OR) begin
            assert_or_R4: assert (result_out == (a_in | b_in));
        end
        if (op_sel == SEL_XOR) begin
            assert_xor_R5: assert (result_out == (a_in ^ b_in));
        end
        if (op_sel == SEL_NOR) begin
            assert_nor_R6: assert (result_out == ~(a_in | b_in));
        end
        if (op_sel == SEL_SLT) begin
            assert_slt_R7: assert (result_out == {{(WIDTH-1){1'b0}}, diff_ref[WIDTH-1]});
        end
        assert_zero_flag_R8: assert (zero_out == (result_out == '0));
    end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .SEL_WIDTH(SEL_WIDTH)) u_chk (
    .a_in       (a_in),
    .b_in       (b_in),
    .op_sel     (op_sel),
    .result_out (result_out),
    .zero_out   (zero_out)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;

    localparam int unsigned W        = 32;
    localparam int unsigned N_RAND   = 3000;
    localparam int unsigned WATCHDOG = 100000;

    typedef struct {
        logic [3:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] exp_res;
        logic         exp_zero;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [3:0]   op_sel = 4'b0000;
    logic [W-1:0] result_out;
    logic         zero_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit drv_done = 1'b0;
    bit finished = 1'b0;
    item_t sb[$];

    always #5 clk = ~clk;

    alu_core u0 (
        .a_in       (a_in),
        .b_in       (b_in),
        .op_sel     (op_sel),
        .result_out (result_out),
        .zero_out   (zero_out)
    );

    // independent behavioural model built from the requirements
    function automatic logic [W-1:0] model(input logic [3:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic [63:0] wide;
        case (op)
            4'b0000: begin wide = {32'd0, a} + {32'd0, b}; return wide[31:0]; end
            4'b0010: begin wide = {32'd0, a} - {32'd0, b}; return wide[31:0]; end
            4'b0100: return a & b;
            4'b0101: return a | b;
            4'b0110: return a ^ b;
            4'b0111: return ~(a | b);
            4'b1010: begin wide = {32'd0, a} - {32'd0, b}; return {31'd0, wide[31]}; end
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'b0000: return "R1";
            4'b0010: return "R2";
            4'b0100: return "R3";
            4'b0101: return "R4";
            4'b0110: return "R5";
            4'b0111: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] exp_res,
                         input string req);
        item_t it;
        @(posedge clk);
        #1;
        op_sel = op;
        a_in   = a;
        b_in   = b;
        it.op = op; it.a = a; it.b = b;
        it.exp_res  = exp_res;
        it.exp_zero = (exp_res == '0);
        it.req      = req;
        sb.push_back(it);
    endtask

    task automatic drive_model(input logic [3:0] op, input logic [W-1:0] a,
                               input logic [W-1:0] b);
        drive(op, a, b, model(op, a, b), req_of(op));
    endtask

    // monitor: outputs are due the same cycle (R9), sampled at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_checks++;
                if (result_out !== it.exp_res) begin
                    n_fails++;
                    $display("FAIL %s/R9 op=%b a=%h b=%h result actual=%h expected=%h",
                             it.req, it.op, it.a, it.b, result_out, it.exp_res);
                end
                n_checks++;
                if (zero_out !== it.exp_zero) begin
                    n_fails++;
                    $display("FAIL R8 op=%b a=%h b=%h zero actual=%b expected=%b",
                             it.op, it.a, it.b, zero_out, it.exp_zero);
                end
            end
        end
    end

    logic [3:0] ops [7] = '{4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1010};
    logic [W-1:0] corners [6] = '{32'h0, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF,
                                  32'h1, 32'h12345678};

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all inputs zero, add gives 0 with zero set (R1, R8)
        drive(4'b0000, 32'h0, 32'h0, 32'h0, "R1");
        // wrap cases
        drive(4'b0000, 32'hFFFFFFFF, 32'h1, 32'h0, "R1");
        drive(4'b0010, 32'h0, 32'h1, 32'hFFFFFFFF, "R2");
        drive(4'b0010, 32'h80000000, 32'h1, 32'h7FFFFFFF, "R2");
        // bitwise fixed patterns
        drive(4'b0100, 32'hF0F0FF00, 32'hFF00F0F0, 32'hF000F000, "R3");
        drive(4'b0101, 32'hF0F00000, 32'h0000FF00, 32'hF0F0FF00, "R4");
        drive(4'b0110, 32'hAAAA5555, 32'hFFFF0000, 32'h55555555, "R5");
        drive(4'b0111, 32'h0, 32'h0, 32'hFFFFFFFF, "R6");
        drive(4'b0111, 32'hFFFF0000, 32'h0000FFFF, 32'h0, "R6");
        // set-less-than without overflow correction
        drive(4'b1010, 32'h7FFFFFFF, 32'h80000000, 32'h1, "R7");
        drive(4'b1010, 32'h80000000, 32'h7FFFFFFF, 32'h0, "R7");
        drive(4'b1010, 32'h5, 32'h5, 32'h0, "R7");
        drive(4'b1010, 32'hFFFFFFFF, 32'h0, 32'h1, "R7");
        // equal operands subtract to zero (R8)
        drive(4'b0010, 32'hDEADBEEF, 32'hDEADBEEF, 32'h0, "R2");
        // corner cross product for every defined select
        foreach (ops[k]) begin
            foreach (corners[i]) begin
                foreach (corners[j]) begin
                    drive_model(ops[k], corners[i], corners[j]);
                end
            end
        end
        // random operands, several thousand per select
        foreach (ops[k]) begin
            for (int n = 0; n < N_RAND; n++) begin
                drive_model(ops[k], $urandom, $urandom);
            end
        end
        drv_done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!(drv_done && sb.size() == 0) && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
        if (cyc >= WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d cycles expected<%0d", cyc, WATCHDOG);
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule